// File: doc/BRIEF.md
# Phase-Switching Dual-Modulus Prescaler

This block divides a fast input clock by 8 or by 9 under control of a single modulus input. A small Johnson counter running on the input clock produces a family of equally spaced phases of a signal at one eighth of the input rate. Neighbouring phases are offset by exactly one input period. A multiplexer picks one of these phases as the divided output.

With the modulus input low the selection stays put and the output period is eight input cycles. With the modulus input high, the selection moves once per output period to the neighbouring phase that lags by one input period. That output period therefore grows to nine cycles. The step is always taken toward the lagging phase, and it is taken just after the output has gone high. The old and new phases are both high at that moment, so the move can never produce a runt pulse. No retiming stage sits between the pointer and the multiplexer.

The block is meant to be the first, fastest stage of a pulse-swallowing programmable divider. The current phase index is also brought out, so later logic can observe where the selection stands.

Top module: `phase_switch_prescaler`

## Requirements
- R1: While `rst` is high at a rising clock edge, the following cycle shows `clk_div` low and `phase_idx` equal to 0.
- R2: With `mod_ctl` held low, successive rising edges of `clk_div` are exactly 8 input clock cycles apart, with 4 cycles high.
- R3: When `mod_ctl` is high at the clock edge that immediately follows a rising edge of `clk_div`, the output period that started with that rising edge lasts exactly 9 input cycles, with 5 cycles high.
- R4: Each period taken as in R3 lowers `phase_idx` by exactly one, and index 0 wraps to index 7.
- R5: A period during which `mod_ctl` is low at the sampling edge leaves `phase_idx` unchanged.
- R6: Neither the high part nor the low part of `clk_div` is ever shorter than 4 input cycles, including across a phase switch.
- R7: After `rst` is released, `clk_div` goes high on the first rising clock edge at which `rst` is sampled low.
- R8: `mod_ctl` is only sampled at the edge that follows a rising edge of `clk_div`. A high pulse on `mod_ctl` at any other time changes neither the period nor `phase_idx`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| mod_ctl | input | 1 | Modulus select: high requests a 9-cycle period |
| clk_div | output | 1 | Divided clock |
| phase_idx | output | 3 | Index of the phase currently selected |

## Verification
The hardest situation to reach is a `mod_ctl` change that lands in cycles other than the single edge after a rising output. Reaching it needs the stimulus to be locked to the output. The driver therefore waits on each rising edge the monitor observes, sets the modulus for that period at once, and in some periods adds a one-cycle stray pulse two cycles later. A long run of high-modulus periods walks the index across the wrap from 0 to 7. Mixed runs of high and low periods then check that each switch lengthens exactly one period and leaves every pulse whole.

// File: rtl/prescaler_pkg.sv
package prescaler_pkg;

    // Polarity of a Johnson counter tap used to build one phase
    typedef enum logic {
        TAP_TRUE = 1'b0,
        TAP_INV  = 1'b1
    } tap_pol_e;

    // Per-cycle decision made by the switch controller
    typedef struct packed {
        logic rise;   // divided output has just gone high
        logic take;   // step to the lagging neighbour this cycle
    } step_flags_t;

    // Raw phase j is tap (j mod half) of the counter, inverted for the upper half.
    function automatic tap_pol_e raw_polarity(int unsigned j, int unsigned n);
        return (j < n / 2) ? TAP_TRUE : TAP_INV;
    endfunction

    function automatic int unsigned raw_tap(int unsigned j, int unsigned n);
        return (j < n / 2) ? j : j - n / 2;
    endfunction

    // Selected index k maps to raw phase (n-k) mod n, so a lower index lags by one cycle.
    function automatic int unsigned raw_of_index(int unsigned k, int unsigned n);
        return (n - k) % n;
    endfunction

endpackage

// File: rtl/johnson_phase_gen.sv
module johnson_phase_gen #(
    parameter int PHASES = 8
) (
    input  logic              clk,
    input  logic              rst,
    output logic [PHASES/2-1:0] jq,
    output logic [PHASES-1:0] phases
);
    import prescaler_pkg::*;

    localparam int HALF = PHASES / 2;

    logic [PHASES-1:0] raw;

    always_ff @(posedge clk) begin
        if (rst) begin
            jq <= '0;
        end else begin
            jq <= {jq[HALF-2:0], ~jq[HALF-1]};
        end
    end

    for (genvar j = 0; j < PHASES; j++) begin : g_raw
        localparam int unsigned TAP = raw_tap(j, PHASES);
        if (raw_polarity(j, PHASES) == TAP_TRUE) begin : g_true
            assign raw[j] = jq[TAP];
        end else begin : g_inv
            assign raw[j] = ~jq[TAP];
        end
    end

    for (genvar k = 0; k < PHASES; k++) begin : g_order
        localparam int unsigned SRC = raw_of_index(k, PHASES);
        assign phases[k] = raw[SRC];
    end

endmodule

// File: rtl/phase_mux.sv
module phase_mux #(
    parameter int PHASES = 8,
    localparam int PTR_W = $clog2(PHASES)
) (
    input  logic [PHASES-1:0] phases,
    input  logic [PTR_W-1:0]  sel,
    output logic              out
);
    logic [PHASES-1:0] hit;

    for (genvar k = 0; k < PHASES; k++) begin : g_leg
        assign hit[k] = phases[k] & (sel == PTR_W'(k));
    end

    assign out = |hit;

endmodule

// File: rtl/switch_ctrl.sv
module switch_ctrl #(
    parameter int PHASES = 8,
    localparam int PTR_W = $clog2(PHASES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mux_out,
    input  logic             mod_ctl,
    output logic [PTR_W-1:0] ptr
);
    import prescaler_pkg::*;

    logic        out_d;
    step_flags_t flags;

    always_comb begin
        flags.rise = mux_out & ~out_d;
        flags.take = flags.rise & mod_ctl;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_d <= 1'b0;
            ptr   <= '0;
        end else begin
            out_d <= mux_out;
            if (flags.take) begin
                // step toward the lagging phase while both old and new are high
                ptr <= (ptr == '0) ? PTR_W'(PHASES - 1) : ptr - 1'b1;
            end
        end
    end

endmodule

// File: rtl/phase_switch_prescaler.sv
module phase_switch_prescaler #(
    parameter int PHASES = 8,
    localparam int PTR_W = $clog2(PHASES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mod_ctl,
    output logic             clk_div,
    output logic [PTR_W-1:0] phase_idx
);
    logic [PHASES/2-1:0] jq;
    logic [PHASES-1:0]   phases;
    logic                mux_out;

    johnson_phase_gen #(.PHASES(PHASES)) u_gen (
        .clk    (clk),
        .rst    (rst),
        .jq     (jq),
        .phases (phases)
    );

    phase_mux #(.PHASES(PHASES)) u_mux (
        .phases (phases),
        .sel    (phase_idx),
        .out    (mux_out)
    );

    switch_ctrl #(.PHASES(PHASES)) u_ctl (
        .clk     (clk),
        .rst     (rst),
        .mux_out (mux_out),
        .mod_ctl (mod_ctl),
        .ptr     (phase_idx)
    );

    assign clk_div = mux_out;

endmodule

// File: rtl/prescaler_checker.sv
module prescaler_checker #(
    parameter int PHASES = 8,
    localparam int PTR_W = $clog2(PHASES)
) (
    input logic               clk,
    input logic               rst,
    input logic               mod_ctl,
    input logic               clk_div,
    input logic [PTR_W-1:0]   phase_idx,
    input logic [PHASES/2-1:0] jq
);

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (phase_idx == '0 && !clk_div));

    // R2: the phase source advances by exactly one bit per input cycle
    p_one_bit_step_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ($countones(jq ^ $past(jq)) == 1));

    p_step_back_r4: assert property (@(posedge clk) disable iff (rst)
        !$stable(phase_idx) |->
        (phase_idx == (($past(phase_idx) == '0) ? PTR_W'(PHASES - 1)
                                                 : PTR_W'($past(phase_idx) - 1'b1))));

    p_hold_when_low_r5: assert property (@(posedge clk) disable iff (rst)
        !$stable(phase_idx) |-> $past(mod_ctl));

    p_min_high_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(clk_div) |=> clk_div);

    p_min_low_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(clk_div) |=> !clk_div);

    p_step_at_rise_r8: assert property (@(posedge clk) disable iff (rst)
        !$stable(phase_idx) |-> ($past(clk_div) && !$past(clk_div, 2)));

endmodule

bind phase_switch_prescaler prescaler_checker #(.PHASES(PHASES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mod_ctl   (mod_ctl),
    .clk_div   (clk_div),
    .phase_idx (phase_idx),
    .jq        (jq)
);

// File: tb/tb_phase_switch_prescaler.sv
module tb_phase_switch_prescaler;

    localparam int CLK_PERIOD = 10;
    localparam int PH         = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mod_ctl = 1'b0;
    logic       clk_div;
    logic [2:0] phase_idx;

    always #(CLK_PERIOD / 2) clk = ~clk;

    phase_switch_prescaler #(.PHASES(PH)) dut (
        .clk       (clk),
        .rst       (rst),
        .mod_ctl   (mod_ctl),
        .clk_div   (clk_div),
        .phase_idx (phase_idx)
    );

    typedef struct {
        int len;
        int high;
        int idx;
    } exp_t;

    exp_t  sb[$];
    int    n_checks = 0;
    int    n_fail   = 0;
    int    cyc      = 0;
    int    last_rise = -1;
    int    hi_cnt   = 0;
    int    hi_last  = 0;
    int    exp_idx  = 0;
    logic  prev_div = 1'b0;
    time   rel_time;
    event  rise_ev;

    task automatic check(input string req, input int act, input int exp_v, input string what);
        n_checks++;
        if (act != exp_v) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp_v);
        end
    endtask

    // monitor: measures each period and compares it with the scoreboard
    always @(negedge clk) begin
        cyc++;
        if (rst) begin
            last_rise = -1;
            prev_div  = 1'b0;
            hi_cnt    = 0;
            sb.delete();
        end else begin
            if (clk_div && !prev_div) begin
                if (last_rise >= 0 && sb.size() > 0) begin
                    exp_t e;
                    e = sb.pop_front();
                    check((e.len == 9) ? "R3" : "R2", cyc - last_rise, e.len, "period");
                    check("R6", hi_last, e.high, "high cycles");
                    check((e.len == 9) ? "R4" : "R5", int'(phase_idx), e.idx, "phase index");
                end
                last_rise = cyc;
                hi_cnt    = 0;
                -> rise_ev;
            end
            if (!clk_div && prev_div) hi_last = hi_cnt;
            if (clk_div) hi_cnt++;
            prev_div = clk_div;
        end
    end

    // driver: called right after a rise; sets modulus for this period and pushes expectation
    task automatic run_period(input logic m, input logic stray);
        exp_t e;
        mod_ctl = m;
        if (m) exp_idx = (exp_idx == 0) ? PH - 1 : exp_idx - 1;
        e.len  = m ? 9 : 8;
        e.high = m ? 5 : 4;
        e.idx  = exp_idx;
        sb.push_back(e);
        if (stray) begin
            // R8: pulse away from the sampling edge must be ignored
            repeat (2) @(negedge clk);
            mod_ctl = 1'b1;
            @(negedge clk);
            mod_ctl = 1'b0;
        end
        @(rise_ev);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL R2 watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        check("R1", int'(clk_div), 0, "clk_div in reset");
        check("R1", int'(phase_idx), 0, "phase_idx in reset");

        rst = 1'b0;
        rel_time = $time;
        @(rise_ev);
        check("R7", int'(($time - rel_time) / CLK_PERIOD), 1, "cycles to first rise");

        for (int i = 0; i < 6; i++) run_period(1'b0, 1'b0);
        for (int i = 0; i < 10; i++) run_period(1'b1, 1'b0);   // crosses 0 -> 7 wrap (R4)
        for (int i = 0; i < 8; i++) run_period(i[0], 1'b0);
        for (int i = 0; i < 5; i++) run_period(1'b0, 1'b1);
        for (int i = 0; i < 4; i++) run_period(i < 2, 1'b0);
        mod_ctl = 1'b0;

        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", int'(clk_div), 0, "clk_div after second reset");
        check("R1", int'(phase_idx), 0, "phase_idx after second reset");

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule